// File: doc/BRIEF.md
# Ternary Synaptic Weight Bank

This block is a small store of synaptic weights for an event-driven neuron core. It has one entry per source ID. Each entry is held as a signed two's-complement value of `WEIGHT_W` bits, but only three values can ever be committed: -1, 0 and +1. There are two write ports. The host uses one to program weights directly. The learning datapath uses the other to write back a proposed new weight after a plasticity update. Both ports pass their value through a clamp before storage: a positive value becomes +1, a negative value becomes -1, and zero stays zero.

A combinational read port returns the entry selected by a source ID. The core uses it to fetch the weight of the synapse that carries the current event. Only the active-low hard reset clears the contents. The bank has no other clear path, so a soft reinitialisation of the surrounding neuron state leaves the weights in place.

When both writers are enabled in the same cycle, they are served independently when their indices differ. When they target the same entry, the host value is the one committed. A library option can swap this priority, and another option selects how the clamped values are held internally.

Top module: `syn_tern_bank`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every entry reads 0 (4'b0000). Reset applied again after writes clears every entry.
- R2: A host write (`host_we`=1) of any positive value (+1..+7) commits +1 (4'b0001) to entry `host_idx`.
- R3: A host write of any negative value, the most negative code -8 (4'b1000) included, commits -1 (4'b1111).
- R4: A host write of 0 commits 0, including over an entry that held +1 or -1.
- R5: A learning writeback (`learn_we`=1) to entry `learn_idx` is clamped with the same rule: positive to 4'b0001, negative to 4'b1111, zero to 4'b0000.
- R6: When both write enables are high and `host_idx` equals `learn_idx`, the entry takes the clamped host value and the learning value is discarded.
- R7: When both write enables are high with different indices, both entries are updated in that same clock edge.
- R8: `rd_val` follows `rd_idx` combinationally within the cycle. A write becomes visible right after the rising edge that captures it, and before that edge the old value is still read.
- R9: With both write enables low, no entry changes, whatever values sit on the index and data inputs.
- R10: `rd_val` is always one of 4'b0000, 4'b0001 or 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low hard reset, clears all entries |
| host_we | input | 1 | Host write enable |
| host_idx | input | 4 | Entry written by the host |
| host_val | input | 4 | Proposed host weight, signed |
| learn_we | input | 1 | Learning writeback enable |
| learn_idx | input | 4 | Entry written by the learning path |
| learn_val | input | 4 | Proposed learned weight, signed |
| rd_idx | input | 4 | Source ID to read |
| rd_val | output | 4 | Stored weight of entry `rd_idx`, signed |

## Verification
A write takes exactly one register stage. The clamped value appears on `rd_val` after the rising edge that samples the enable. A change of `rd_idx` reaches `rd_val` within the same cycle, with no edge in between.

The bench changes every input on the falling edge and samples `rd_val` 2 ns later. That sample reflects the contents as they stood before the coming rising edge. The behavioural model is updated only after that edge, so each comparison sees the write of the previous cycle and never the pending one. The same-index collision and the read-during-write case are both covered by this per-cycle comparison.

// File: rtl/syn_tern_pkg.sv
package syn_tern_pkg;

   // Two-bit internal code for a ternary weight: {negative, nonzero}
   typedef logic [1:0] tern_code_t;

   localparam tern_code_t TC_ZERO = 2'b00;
   localparam tern_code_t TC_POS  = 2'b01;
   localparam tern_code_t TC_NEG  = 2'b11;

   // Priority selection for same-entry collisions
   localparam bit PRIO_HOST  = 1'b1;
   localparam bit PRIO_LEARN = 1'b0;

endpackage

// File: rtl/syn_tern_clamp.sv
module syn_tern_clamp
   import syn_tern_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] raw,
   output tern_code_t   code
);

   logic is_zero;
   logic is_neg;

   assign is_zero = (raw == '0);
   assign is_neg  = raw[W-1];

   always_comb begin
      if (is_zero)     code = TC_ZERO;
      else if (is_neg) code = TC_NEG;
      else             code = TC_POS;
   end

endmodule

// File: rtl/syn_tern_arb.sv
module syn_tern_arb
   import syn_tern_pkg::*;
#(
   parameter int N          = 16,
   parameter int IDX_W      = 4,
   parameter bit HOST_FIRST = PRIO_HOST
) (
   input  logic                   host_we,
   input  logic [IDX_W-1:0]       host_idx,
   input  tern_code_t             host_code,
   input  logic                   learn_we,
   input  logic [IDX_W-1:0]       learn_idx,
   input  tern_code_t             learn_code,
   output logic [N-1:0]           wr_en,
   output logic [N-1:0][1:0]      wr_code
);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_entry
         logic host_hit;
         logic learn_hit;

         assign host_hit  = host_we  && (host_idx  == IDX_W'(gi));
         assign learn_hit = learn_we && (learn_idx == IDX_W'(gi));
         assign wr_en[gi] = host_hit | learn_hit;

         if (HOST_FIRST) begin : g_host_wins
            assign wr_code[gi] = host_hit ? host_code : learn_code;
         end else begin : g_learn_wins
            assign wr_code[gi] = learn_hit ? learn_code : host_code;
         end
      end
   endgenerate

endmodule

// File: rtl/syn_tern_store.sv
module syn_tern_store
   import syn_tern_pkg::*;
#(
   parameter int N       = 16,
   parameter int W       = 4,
   parameter int IDX_W   = 4,
   parameter bit COMPACT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         wr_en,
   input  logic [N-1:0][1:0]    wr_code,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [W-1:0]         rd_val
);

   function automatic logic [W-1:0] expand(input tern_code_t c);
      expand = {{(W-1){c == TC_NEG}}, (c != TC_ZERO)};
   endfunction

   logic [N-1:0][W-1:0] view;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_cell
         if (COMPACT) begin : g_code
            tern_code_t cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          cell_q <= TC_ZERO;
               else if (wr_en[gi])  cell_q <= wr_code[gi];
            end
            assign view[gi] = expand(cell_q);
         end else begin : g_wide
            logic [W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          val_q <= '0;
               else if (wr_en[gi])  val_q <= expand(wr_code[gi]);
            end
            assign view[gi] = val_q;
         end
      end
   endgenerate

   assign rd_val = view[rd_idx];

endmodule

// File: rtl/syn_tern_bank.sv
module syn_tern_bank
   import syn_tern_pkg::*;
#(
   parameter int NUM_ENTRIES   = 16,
   parameter int WEIGHT_W      = 4,
   parameter bit HOST_FIRST    = PRIO_HOST,
   parameter bit COMPACT_STORE = 1'b1,
   localparam int IDX_W        = $clog2(NUM_ENTRIES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_we,
   input  logic [IDX_W-1:0]    host_idx,
   input  logic [WEIGHT_W-1:0] host_val,
   input  logic                learn_we,
   input  logic [IDX_W-1:0]    learn_idx,
   input  logic [WEIGHT_W-1:0] learn_val,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [WEIGHT_W-1:0] rd_val
);

   generate
      if (NUM_ENTRIES < 2) begin : g_bad_depth
         $error("syn_tern_bank: NUM_ENTRIES must be at least 2");
      end
      if ((1 << IDX_W) != NUM_ENTRIES) begin : g_bad_pow2
         $error("syn_tern_bank: NUM_ENTRIES must be a power of two");
      end
      if (WEIGHT_W < 2) begin : g_bad_width
         $error("syn_tern_bank: WEIGHT_W must be at least 2 to hold -1");
      end
   endgenerate

   tern_code_t                   host_code;
   tern_code_t                   learn_code;
   logic [NUM_ENTRIES-1:0]       wr_en;
   logic [NUM_ENTRIES-1:0][1:0]  wr_code;

   syn_tern_clamp #(.W(WEIGHT_W)) u_clamp_host (
      .raw  (host_val),
      .code (host_code)
   );

   syn_tern_clamp #(.W(WEIGHT_W)) u_clamp_learn (
      .raw  (learn_val),
      .code (learn_code)
   );

   syn_tern_arb #(
      .N          (NUM_ENTRIES),
      .IDX_W      (IDX_W),
      .HOST_FIRST (HOST_FIRST)
   ) u_arb (
      .host_we    (host_we),
      .host_idx   (host_idx),
      .host_code  (host_code),
      .learn_we   (learn_we),
      .learn_idx  (learn_idx),
      .learn_code (learn_code),
      .wr_en      (wr_en),
      .wr_code    (wr_code)
   );

   syn_tern_store #(
      .N       (NUM_ENTRIES),
      .W       (WEIGHT_W),
      .IDX_W   (IDX_W),
      .COMPACT (COMPACT_STORE)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_code (wr_code),
      .rd_idx  (rd_idx),
      .rd_val  (rd_val)
   );

endmodule

// File: rtl/syn_tern_bank_chk.sv
module syn_tern_bank_chk #(
   parameter int IDX_W      = 4,
   parameter int W          = 4,
   parameter bit HOST_FIRST = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_we,
   input logic [IDX_W-1:0] host_idx,
   input logic [W-1:0]     host_val,
   input logic             learn_we,
   input logic [IDX_W-1:0] learn_idx,
   input logic [W-1:0]     learn_val,
   input logic [IDX_W-1:0] rd_idx,
   input logic [W-1:0]     rd_val
);

   function automatic logic [W-1:0] tern(input logic [W-1:0] v);
      if (v == '0)       return '0;
      else if (v[W-1])   return '1;
      else               return W'(1);
   endfunction

   logic fresh_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fresh_q <= 1'b1;
      else        fresh_q <= 1'b0;
   end

   logic collide;
   assign collide = host_we && learn_we && (host_idx == learn_idx);

   // R1: first cycle after reset release reads zero
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fresh_q |-> (rd_val == '0));

   // R2: host value lands clamped when read at same index next cycle
   p_host_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && (host_idx == rd_idx) && (HOST_FIRST || !collide))
      |=> ((rd_idx != $past(rd_idx)) || (rd_val == tern($past(host_val)))));

   // R5: learning value lands clamped when not overridden
   p_learn_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (learn_we && (learn_idx == rd_idx) && (!HOST_FIRST || !collide))
      |=> ((rd_idx != $past(rd_idx)) || (rd_val == tern($past(learn_val)))));

   // R6: collision resolves to the priority writer
   p_collide_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (collide && (host_idx == rd_idx))
      |=> ((rd_idx != $past(rd_idx)) ||
           (rd_val == (HOST_FIRST ? tern($past(host_val)) : tern($past(learn_val))))));

   // R9: idle cycle leaves the read entry unchanged
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_we && !learn_we) |=> ((rd_idx != $past(rd_idx)) || $stable(rd_val)));

   // R10: only ternary codes are ever visible
   p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_val == '0) || (rd_val == W'(1)) || (rd_val == '1));

endmodule

bind syn_tern_bank syn_tern_bank_chk #(
   .IDX_W      (IDX_W),
   .W          (WEIGHT_W),
   .HOST_FIRST (HOST_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_idx  (host_idx),
   .host_val  (host_val),
   .learn_we  (learn_we),
   .learn_idx (learn_idx),
   .learn_val (learn_val),
   .rd_idx    (rd_idx),
   .rd_val    (rd_val)
);

// File: tb/syn_tern_bank_bench.sv
`timescale 1ns/1ps
module syn_tern_bank_bench;

   localparam int N = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [3:0] host_idx = '0;
   logic [3:0] host_val = '0;
   logic       learn_we = 1'b0;
   logic [3:0] learn_idx = '0;
   logic [3:0] learn_val = '0;
   logic [3:0] rd_idx = '0;
   logic [3:0] rd_val;

   int checks = 0;
   int fails  = 0;
   int model [N];

   always #10 clk = ~clk;

   syn_tern_bank u_syn_tern_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_we),
      .host_idx  (host_idx),
      .host_val  (host_val),
      .learn_we  (learn_we),
      .learn_idx (learn_idx),
      .learn_val (learn_val),
      .rd_idx    (rd_idx),
      .rd_val    (rd_val)
   );

   function automatic int clamp3(input logic [3:0] v);
      int s;
      s = $signed(v);
      if (s > 0) return 1;
      if (s < 0) return -1;
      return 0;
   endfunction

   task automatic check_read(input string req);
      int got;
      got = $signed(rd_val);
      checks++;
      if (got != model[rd_idx]) begin
         fails++;
         $display("FAIL %s idx=%0d actual=%0d expected=%0d", req, rd_idx, got, model[rd_idx]);
      end
   endtask

   // One cycle: drive at falling edge, check pre-edge contents, then commit in model
   task automatic step(input logic hw, input logic [3:0] hi, input logic [3:0] hv,
                       input logic lw, input logic [3:0] li, input logic [3:0] lv,
                       input logic [3:0] ri, input string req);
      @(negedge clk);
      host_we = hw; host_idx = hi; host_val = hv;
      learn_we = lw; learn_idx = li; learn_val = lv;
      rd_idx = ri;
      #2;
      check_read(req);
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (lw) model[li] = clamp3(lv);
         if (hw) model[hi] = clamp3(hv);
      end
   endtask

   task automatic idle_read(input logic [3:0] ri, input string req);
      step(1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0, ri, req);
   endtask

   task automatic scan(input string req);
      for (int i = 0; i < N; i++) idle_read(4'(i), req);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int i = 0; i < N; i++) model[i] = 0;

      // R1: reads during reset are zero
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         rd_idx = 4'(i);
         #2;
         check_read("R1");
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R1: first cycle after release
      idle_read(4'd5, "R1");

      // R2: positive host values clamp to +1
      step(1'b1, 4'd3, 4'd7, 1'b0, 4'd0, 4'd0, 4'd3, "R2");
      step(1'b1, 4'd4, 4'd1, 1'b0, 4'd0, 4'd0, 4'd3, "R2");
      step(1'b1, 4'd5, 4'd3, 1'b0, 4'd0, 4'd0, 4'd4, "R2");
      idle_read(4'd5, "R2");

      // R3: negative host values, including -8, clamp to -1
      step(1'b1, 4'd6, 4'b1000, 1'b0, 4'd0, 4'd0, 4'd6, "R3");
      step(1'b1, 4'd7, 4'b1111, 1'b0, 4'd0, 4'd0, 4'd6, "R3");
      step(1'b1, 4'd8, 4'b1011, 1'b0, 4'd0, 4'd0, 4'd7, "R3");
      idle_read(4'd8, "R3");

      // R4: zero overwrites +1 and -1
      step(1'b1, 4'd3, 4'd0, 1'b0, 4'd0, 4'd0, 4'd3, "R4");
      step(1'b1, 4'd6, 4'd0, 1'b0, 4'd0, 4'd0, 4'd3, "R4");
      idle_read(4'd6, "R4");

      // R5: learning writeback clamped
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd9,  4'd6,    4'd9,  "R5");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd10, 4'b1101, 4'd9,  "R5");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd4,  4'd0,    4'd10, "R5");
      idle_read(4'd4, "R5");

      // R6: same-index collision, host wins
      step(1'b1, 4'd11, 4'b1110, 1'b1, 4'd11, 4'd5,    4'd11, "R6");
      step(1'b1, 4'd11, 4'd2,    1'b1, 4'd11, 4'b1001, 4'd11, "R6");
      step(1'b1, 4'd11, 4'd0,    1'b1, 4'd11, 4'd4,    4'd11, "R6");
      idle_read(4'd11, "R6");

      // R7: different indices both commit
      step(1'b1, 4'd12, 4'd2, 1'b1, 4'd13, 4'b1001, 4'd12, "R7");
      idle_read(4'd12, "R7");
      idle_read(4'd13, "R7");

      // R8: read of the entry being written shows old value before the edge
      step(1'b1, 4'd14, 4'd5, 1'b0, 4'd0, 4'd0, 4'd14, "R8");
      step(1'b1, 4'd14, 4'b1100, 1'b0, 4'd0, 4'd0, 4'd14, "R8");
      idle_read(4'd14, "R8");

      // R9: idle cycles with live data on the inputs change nothing
      for (int i = 0; i < 8; i++)
         step(1'b0, 4'(i), 4'd7, 1'b0, 4'(15 - i), 4'b1000, 4'(i), "R9");
      scan("R9");

      // R10: random mixed traffic, every read is ternary and matches model
      for (int i = 0; i < 400; i++)
         step(1'($urandom), 4'($urandom), 4'($urandom),
              1'($urandom), 4'($urandom), 4'($urandom),
              4'($urandom), "R10");
      scan("R10");

      // R1: reset again after writes clears all entries
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) model[i] = 0;
      #2;
      for (int i = 0; i < N; i++) begin
         rd_idx = 4'(i);
         #1;
         check_read("R1");
      end
      @(negedge clk);
      rst_n = 1'b1;
      scan("R1");

      summary();
   end

endmodule